// File: doc/BRIEF.md
# Logical Device Configuration Register File

This block holds the configuration state of one logical device on a plug-and-play expansion card. A card-level controller decodes the configuration protocol. While the card is in its configuration state and this device is the selected one, the controller raises `cfg_sel` and reaches the bank by an 8-bit register index. Writes take effect on the next clock edge. Reads are combinational from the current index.

The bank stores the device's activation bit and its conflict-probe control. It also stores eight I/O base addresses, two interrupt entries, two DMA channel selections and four memory-range descriptors. The memory descriptors are storage only. From this state the block drives the signals the rest of the device uses: the activation flag, the I/O bases with per-range decode hits, the interrupt number and trigger mode, and a one-hot DMA channel enable.

It also answers the conflict probe. While the device is inactive and the probe is armed, a read that lands in any of its assigned I/O windows is answered with a fixed byte pattern instead of normal decode. The configuration-control reset and the block reset both return every register to zero.

Top module: `ldev_cfg_regs`

## Requirements
- R1: Index 0x30 bit 0 is the activation bit and drives `dev_active`. Bits [7:1] always read as 0.
- R2: Index 0x31 stores bit 1 (probe armed) and bit 0 (pattern select). Bits [7:2] always read as 0.
- R3: A probe answer is given when all of these hold: `io_rd` is high, the device is inactive, probe-armed is set, and `io_addr` lies in an assigned window. The answer sets `chk_resp_vld` and drives `chk_resp_data` to 0x55 if pattern select is 1 and 0xAA if it is 0. Otherwise `chk_resp_data` is 0.
- R4: `io_hit[i]` is high only when `io_rd` is high, the device is active and range i matches. The probe answer never appears while active. The probe answer and `io_hit` are never high together.
- R5: A write of 1 to activation bit 0 also clears probe-armed (0x31 bit 1) in the same cycle.
- R6: Range i has its base high byte at index 0x60+2i and its low byte at 0x61+2i, and `io_base[16i+15:16i]` exports the pair. Range i matches when the base is non-zero and `io_addr` equals the base with the low IO_SPAN_W bits (3 by default) ignored.
- R7: Interrupt entry k has its level at index 0x70+2k, stored in bits [3:0] and exported on `irq_num`. Its mode byte is at 0x71+2k: bit 1 is polarity (1 = active high) and bit 0 is trigger (1 = level, 0 = edge). All other bits read as 0.
- R8: DMA entry j sits at index 0x74+j with channel in bits [2:0], and the other bits read 0. While active, `dma_en` bit c is set for each entry selecting channel c other than 4. Channel 4 means no DMA. While inactive, `dma_en` is 0.
- R9: Memory range r occupies indices 0x40+8r to 0x47+8r. Offsets 0, 1, 3 and 4 are full read/write bytes. At offset 2, bit 1 (16-bit width) is writable and bit 0 is read-only, equal to parameter MEM_LIMIT_MODE. Offsets 5 to 7 and every other unlisted index read as 0 and ignore writes.
- R10: Writes take effect only when `cfg_sel` and `cfg_wr` are both high. `cfg_rdata` is 0 whenever `cfg_sel` is low.
- R11: A cycle with `cc_reset` high clears every register of the bank to zero, which deactivates the device. It wins over a write in the same cycle.
- R12: A clock edge with `rst_n` low clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cc_reset | input | 1 | Configuration-control reset pulse from the card controller |
| cfg_sel | input | 1 | Card in configuration state with this device selected |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the indexed register |
| io_rd | input | 1 | Bus I/O read cycle in progress |
| io_addr | input | 16 | Bus I/O address |
| io_hit | output | N_IO | Per-range decode hit while active |
| chk_resp_vld | output | 1 | Conflict-probe answer is being driven |
| chk_resp_data | output | 8 | Conflict-probe answer byte |
| dev_active | output | 1 | Device enabled on the bus |
| io_base | output | 16*N_IO | Flattened I/O base addresses |
| irq_num | output | 4*N_IRQ | Flattened interrupt levels |
| irq_level_trig | output | N_IRQ | 1 = level triggered, 0 = edge |
| irq_active_high | output | N_IRQ | 1 = active-high polarity |
| dma_en | output | 8 | One-hot-per-entry DMA channel enables |

## Verification
The bench builds the block with its default parameters: eight I/O ranges, two interrupt entries, two DMA entries, four memory ranges, an 8-port decode window and a zero read-only memory control bit. These are the values at which the index layout is packed solid from 0x60 to 0x75. Every documented index is therefore reachable, together with the gaps that must read 0. The 8-port window lets random probe addresses fall both inside and just outside a programmed range. A behavioural model is compared on every cycle while the activation, probe arming and resets are exercised, including activation that clears an armed probe and a reset that collides with a write.

// File: rtl/ldev_cfg_pkg.sv
// Shared constants of the logical device configuration bank.
// Assumes the fixed index layout that the card controller decodes.
package ldev_cfg_pkg;
    localparam logic [7:0] IDX_ACT  = 8'h30;
    localparam logic [7:0] IDX_CHK  = 8'h31;
    localparam logic [7:0] IDX_MEM  = 8'h40;
    localparam logic [7:0] IDX_IO   = 8'h60;
    localparam logic [7:0] IDX_IRQ  = 8'h70;
    localparam logic [7:0] IDX_DMA  = 8'h74;
    localparam int         MEM_STRIDE = 8;
    localparam logic [7:0] PAT_ONE  = 8'h55;
    localparam logic [7:0] PAT_ZERO = 8'hAA;
    localparam logic [2:0] DMA_NONE = 3'd4;
endpackage

// File: rtl/ldev_ctl.sv
// Activation and conflict-probe control of one logical device.
// Holds the activation bit and probe control, and forms the probe answer.
// Assumes wr_en is already qualified by selection.
module ldev_ctl
    import ldev_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [1:0] wbits,
    input  logic       io_rd,
    input  logic       range_hit,
    output logic       active,
    output logic       chk_en,
    output logic       resp_vld,
    output logic [7:0] resp_data,
    output logic [7:0] rdata
);
    logic       act_q;
    logic [1:0] chk_q;

    // Register update: reset, then writes. Turning the device on disarms the probe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            act_q <= 1'b0;
            chk_q <= 2'b00;
        end else if (wr_en) begin
            if (idx == IDX_ACT) begin
                act_q <= wbits[0];
                if (wbits[0]) chk_q[1] <= 1'b0;
            end else if (idx == IDX_CHK) begin
                chk_q <= wbits;
            end
        end
    end

    // Probe answer: only for an inactive device with the probe armed.
    always_comb begin
        resp_vld  = io_rd && !act_q && chk_q[1] && range_hit;
        resp_data = 8'h00;
        if (resp_vld) resp_data = chk_q[0] ? PAT_ONE : PAT_ZERO;
    end

    // Read-back of the two control indices, reserved bits zero.
    always_comb begin
        rdata = 8'h00;
        if (idx == IDX_ACT) rdata = {7'b0, act_q};
        else if (idx == IDX_CHK) rdata = {6'b0, chk_q};
    end

    assign active = act_q;
    assign chk_en = chk_q[1];
endmodule

// File: rtl/ldev_io_bank.sv
// I/O base address storage and window compare for N_IO ranges.
// A base of zero marks an unassigned range. Windows are 2**SPAN_W ports.
module ldev_io_bank
    import ldev_cfg_pkg::*;
#(
    parameter int N_IO   = 8,
    parameter int SPAN_W = 3
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [7:0]         idx,
    input  logic [7:0]         wdata,
    input  logic [15:0]        io_addr,
    output logic [N_IO-1:0]    hit_raw,
    output logic [16*N_IO-1:0] base_flat,
    output logic [7:0]         rdata
);
    localparam logic [15:0] LOW_MASK = 16'((1 << SPAN_W) - 1);

    logic [7:0] hi_q [N_IO];
    logic [7:0] lo_q [N_IO];

    for (genvar i = 0; i < N_IO; i++) begin : g_rng
        localparam logic [7:0] HI_IDX = 8'(IDX_IO + 2*i);
        localparam logic [7:0] LO_IDX = 8'(IDX_IO + 2*i + 1);

        // Byte registers of range i: high byte first, then low byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                hi_q[i] <= 8'h00;
                lo_q[i] <= 8'h00;
            end else if (wr_en) begin
                if (idx == HI_IDX) hi_q[i] <= wdata;
                if (idx == LO_IDX) lo_q[i] <= wdata;
            end
        end

        // Window compare of range i, ignoring the low address bits.
        always_comb begin
            base_flat[16*i +: 16] = {hi_q[i], lo_q[i]};
            hit_raw[i] = ({hi_q[i], lo_q[i]} != 16'h0000) &&
                         ((io_addr & ~LOW_MASK) == ({hi_q[i], lo_q[i]} & ~LOW_MASK));
        end
    end

    // Read-back over all range bytes.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < N_IO; i++) begin
            if (idx == 8'(IDX_IO + 2*i))     rdata = hi_q[i];
            if (idx == 8'(IDX_IO + 2*i + 1)) rdata = lo_q[i];
        end
    end
endmodule

// File: rtl/ldev_intr_bank.sv
// Interrupt and DMA selection registers and their exported controls.
// Assumes the interrupt entries are two bytes each from IDX_IRQ and the DMA entries one byte each from IDX_DMA.
module ldev_intr_bank
    import ldev_cfg_pkg::*;
#(
    parameter int N_IRQ = 2,
    parameter int N_DMA = 2
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [7:0]         idx,
    input  logic [3:0]         wbits,
    input  logic               active,
    output logic [4*N_IRQ-1:0] irq_num,
    output logic [N_IRQ-1:0]   irq_level_trig,
    output logic [N_IRQ-1:0]   irq_active_high,
    output logic [7:0]         dma_en,
    output logic [7:0]         rdata
);
    logic [3:0] lvl_q  [N_IRQ];
    logic [1:0] mode_q [N_IRQ];
    logic [2:0] ch_q   [N_DMA];

    for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
        // Level and mode bytes of interrupt entry k.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lvl_q[k]  <= 4'h0;
                mode_q[k] <= 2'b00;
            end else if (wr_en) begin
                if (idx == 8'(IDX_IRQ + 2*k))     lvl_q[k]  <= wbits;
                if (idx == 8'(IDX_IRQ + 2*k + 1)) mode_q[k] <= wbits[1:0];
            end
        end
        assign irq_num[4*k +: 4]  = lvl_q[k];
        assign irq_level_trig[k]  = mode_q[k][0];
        assign irq_active_high[k] = mode_q[k][1];
    end

    for (genvar j = 0; j < N_DMA; j++) begin : g_dma
        // Channel select of DMA entry j.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) ch_q[j] <= 3'd0;
            else if (wr_en && idx == 8'(IDX_DMA + j)) ch_q[j] <= wbits[2:0];
        end
    end

    // Channel enables: one bit per entry unless it selects "no DMA" or the device is off.
    always_comb begin
        dma_en = 8'h00;
        for (int j = 0; j < N_DMA; j++)
            if (active && ch_q[j] != DMA_NONE) dma_en[ch_q[j]] = 1'b1;
    end

    // Read-back with reserved bits zero.
    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < N_IRQ; k++) begin
            if (idx == 8'(IDX_IRQ + 2*k))     rdata = {4'h0, lvl_q[k]};
            if (idx == 8'(IDX_IRQ + 2*k + 1)) rdata = {6'h0, mode_q[k]};
        end
        for (int j = 0; j < N_DMA; j++)
            if (idx == 8'(IDX_DMA + j)) rdata = {5'h0, ch_q[j]};
    end
endmodule

// File: rtl/ldev_mem_bank.sv
// Memory range descriptor storage for N_MEM ranges of MEM_STRIDE indices.
// Storage only: nothing decodes these values here. Control bit 0 is a fixed parameter.
module ldev_mem_bank
    import ldev_cfg_pkg::*;
#(
    parameter int   N_MEM          = 4,
    parameter logic MEM_LIMIT_MODE = 1'b0
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    logic [7:0] bhi_q [N_MEM];
    logic [7:0] bmd_q [N_MEM];
    logic       w16_q [N_MEM];
    logic [7:0] lhi_q [N_MEM];
    logic [7:0] lmd_q [N_MEM];

    for (genvar r = 0; r < N_MEM; r++) begin : g_rng
        localparam logic [7:0] B = 8'(IDX_MEM + MEM_STRIDE*r);
        // Descriptor bytes of range r; offset 2 keeps only the width bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                bhi_q[r] <= 8'h00;
                bmd_q[r] <= 8'h00;
                w16_q[r] <= 1'b0;
                lhi_q[r] <= 8'h00;
                lmd_q[r] <= 8'h00;
            end else if (wr_en) begin
                if (idx == B)        bhi_q[r] <= wdata;
                if (idx == B + 8'd1) bmd_q[r] <= wdata;
                if (idx == B + 8'd2) w16_q[r] <= wdata[1];
                if (idx == B + 8'd3) lhi_q[r] <= wdata;
                if (idx == B + 8'd4) lmd_q[r] <= wdata;
            end
        end
    end

    // Read-back; filler offsets return zero.
    always_comb begin
        rdata = 8'h00;
        for (int r = 0; r < N_MEM; r++) begin
            if (idx == 8'(IDX_MEM + MEM_STRIDE*r))     rdata = bhi_q[r];
            if (idx == 8'(IDX_MEM + MEM_STRIDE*r + 1)) rdata = bmd_q[r];
            if (idx == 8'(IDX_MEM + MEM_STRIDE*r + 2)) rdata = {6'h0, w16_q[r], MEM_LIMIT_MODE};
            if (idx == 8'(IDX_MEM + MEM_STRIDE*r + 3)) rdata = lhi_q[r];
            if (idx == 8'(IDX_MEM + MEM_STRIDE*r + 4)) rdata = lmd_q[r];
        end
    end
endmodule

// File: rtl/ldev_cfg_regs.sv
// Top of the logical device configuration register file.
// Qualifies accesses by selection, merges bank read data and gates decode by activation.
// Assumes the caller holds cfg_sel only while the card is configured and this device selected.
module ldev_cfg_regs #(
    parameter int   N_IO           = 8,
    parameter int   N_IRQ          = 2,
    parameter int   N_DMA          = 2,
    parameter int   N_MEM          = 4,
    parameter int   IO_SPAN_W      = 3,
    parameter logic MEM_LIMIT_MODE = 1'b0
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cc_reset,
    input  logic               cfg_sel,
    input  logic               cfg_wr,
    input  logic [7:0]         cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               io_rd,
    input  logic [15:0]        io_addr,
    output logic [N_IO-1:0]    io_hit,
    output logic               chk_resp_vld,
    output logic [7:0]         chk_resp_data,
    output logic               dev_active,
    output logic [16*N_IO-1:0] io_base,
    output logic [4*N_IRQ-1:0] irq_num,
    output logic [N_IRQ-1:0]   irq_level_trig,
    output logic [N_IRQ-1:0]   irq_active_high,
    output logic [7:0]         dma_en
);
    logic            wr_en;
    logic            chk_en;
    logic [N_IO-1:0] hit_raw;
    logic [7:0]      rd_ctl, rd_io, rd_intr, rd_mem;

    assign wr_en = cfg_sel && cfg_wr;

    ldev_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .clr(cc_reset), .wr_en(wr_en),
        .idx(cfg_idx), .wbits(cfg_wdata[1:0]), .io_rd(io_rd),
        .range_hit(|hit_raw), .active(dev_active), .chk_en(chk_en),
        .resp_vld(chk_resp_vld), .resp_data(chk_resp_data), .rdata(rd_ctl)
    );

    ldev_io_bank #(.N_IO(N_IO), .SPAN_W(IO_SPAN_W)) u_io (
        .clk(clk), .rst_n(rst_n), .clr(cc_reset), .wr_en(wr_en),
        .idx(cfg_idx), .wdata(cfg_wdata), .io_addr(io_addr),
        .hit_raw(hit_raw), .base_flat(io_base), .rdata(rd_io)
    );

    ldev_intr_bank #(.N_IRQ(N_IRQ), .N_DMA(N_DMA)) u_intr (
        .clk(clk), .rst_n(rst_n), .clr(cc_reset), .wr_en(wr_en),
        .idx(cfg_idx), .wbits(cfg_wdata[3:0]), .active(dev_active),
        .irq_num(irq_num), .irq_level_trig(irq_level_trig),
        .irq_active_high(irq_active_high), .dma_en(dma_en), .rdata(rd_intr)
    );

    ldev_mem_bank #(.N_MEM(N_MEM), .MEM_LIMIT_MODE(MEM_LIMIT_MODE)) u_mem (
        .clk(clk), .rst_n(rst_n), .clr(cc_reset), .wr_en(wr_en),
        .idx(cfg_idx), .wdata(cfg_wdata), .rdata(rd_mem)
    );

    // Read merge: banks return zero outside their indices; nothing leaves when unselected.
    assign cfg_rdata = cfg_sel ? (rd_ctl | rd_io | rd_intr | rd_mem) : 8'h00;

    // Normal decode only for an active device during a read cycle.
    assign io_hit = (io_rd && dev_active) ? hit_raw : '0;
endmodule

// File: rtl/ldev_cfg_regs_chk.sv
// Property checker for ldev_cfg_regs, attached by bind.
// Observes ports and the probe-armed flag; drives nothing.
module ldev_cfg_regs_chk #(
    parameter int N_IO = 8
)(
    input logic            clk,
    input logic            rst_n,
    input logic            cc_reset,
    input logic            cfg_sel,
    input logic            cfg_wr,
    input logic [7:0]      cfg_idx,
    input logic            wbit0,
    input logic [7:0]      cfg_rdata,
    input logic            dev_active,
    input logic            chk_en,
    input logic            chk_resp_vld,
    input logic [7:0]      chk_resp_data,
    input logic [N_IO-1:0] io_hit,
    input logic [7:0]      dma_en
);
    AST_ACT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_idx == 8'h30) |-> (cfg_rdata[7:1] == 7'h00)); // R1
    AST_RESP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_resp_vld |-> (chk_resp_data == 8'h55 || chk_resp_data == 8'hAA)); // R3
    AST_RESP_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_resp_vld |-> !dev_active); // R4
    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_resp_vld |-> (io_hit == '0)); // R4
    AST_ACT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_wr && cfg_idx == 8'h30 && wbit0 && !cc_reset) |=> (dev_active && !chk_en)); // R5
    AST_DMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active |-> (dma_en == 8'h00)); // R8
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |-> (cfg_rdata == 8'h00)); // R10
    AST_CC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cc_reset |=> (!dev_active && !chk_en)); // R11
endmodule

bind ldev_cfg_regs ldev_cfg_regs_chk #(.N_IO(N_IO)) u_chk (
    .clk(clk), .rst_n(rst_n), .cc_reset(cc_reset), .cfg_sel(cfg_sel),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .wbit0(cfg_wdata[0]),
    .cfg_rdata(cfg_rdata), .dev_active(dev_active), .chk_en(chk_en),
    .chk_resp_vld(chk_resp_vld), .chk_resp_data(chk_resp_data),
    .io_hit(io_hit), .dma_en(dma_en)
);

// File: tb/sim_ldev_cfg_regs.sv
// Bench: byte-array reference model compared with the outputs on every falling edge.
module sim_ldev_cfg_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 0;
    logic        rst_n = 0, cc_reset = 0, cfg_sel = 0, cfg_wr = 0, io_rd = 0;
    logic [7:0]  cfg_idx = 0, cfg_wdata = 0;
    logic [15:0] io_addr = 0;
    logic [7:0]  cfg_rdata, chk_resp_data, dma_en;
    logic [7:0]  io_hit;
    logic        chk_resp_vld, dev_active;
    logic [127:0] io_base;
    logic [7:0]  irq_num;
    logic [1:0]  irq_level_trig, irq_active_high;

    int vectors = 0, fails = 0;
    bit started = 0;
    int m [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldev_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .cc_reset(cc_reset), .cfg_sel(cfg_sel),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_rd(io_rd), .io_addr(io_addr),
        .io_hit(io_hit), .chk_resp_vld(chk_resp_vld),
        .chk_resp_data(chk_resp_data), .dev_active(dev_active),
        .io_base(io_base), .irq_num(irq_num), .irq_level_trig(irq_level_trig),
        .irq_active_high(irq_active_high), .dma_en(dma_en)
    );

    // Writable bits of each index, from the requirements.
    function automatic int wmask(int i);
        if (i == 'h30) return 'h01;                       // R1
        if (i == 'h31) return 'h03;                       // R2
        if (i >= 'h40 && i < 'h60) begin                  // R9
            case (i % 8)
                0, 1, 3, 4: return 'hFF;
                2:          return 'h02;
                default:    return 0;
            endcase
        end
        if (i >= 'h60 && i < 'h70) return 'hFF;           // R6
        if (i == 'h70 || i == 'h72) return 'h0F;          // R7
        if (i == 'h71 || i == 'h73) return 'h03;          // R7
        if (i == 'h74 || i == 'h75) return 'h07;          // R8
        return 0;
    endfunction

    function automatic string tag_of(int i);
        if (!cfg_sel) return "R10";
        if (i == 'h30) return "R1";
        if (i == 'h31) return "R2";
        if (i >= 'h60 && i < 'h70) return "R6";
        if (i >= 'h70 && i < 'h74) return "R7";
        if (i == 'h74 || i == 'h75) return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference update: R12 reset, R11 control reset over writes, R10 qualified writes, R5 disarm.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n || cc_reset) begin
            for (int i = 0; i < 256; i++) m[i] = 0;
        end else if (cfg_sel && cfg_wr) begin
            m[cfg_idx] = cfg_wdata & wmask(cfg_idx);
            if (cfg_idx == 8'h30 && cfg_wdata[0]) m['h31] = m['h31] & ~2;
        end
    end

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (started && rst_n) begin
            int act, base, hr, eh, evld, edma;
            act  = m['h30] & 1;
            hr = 0;
            for (int i = 0; i < 8; i++) begin
                base = m['h60 + 2*i] * 256 + m['h61 + 2*i];
                if (base != 0 && (io_addr >> 3) == (base >> 3)) hr |= (1 << i);
                check("R6", io_base[16*i +: 16], base);
            end
            eh   = (io_rd && act) ? hr : 0;
            evld = (io_rd && !act && m['h31][1] && hr != 0) ? 1 : 0;
            check(tag_of(cfg_idx), cfg_rdata, cfg_sel ? m[cfg_idx] : 0);
            check("R1", dev_active, act);
            check(act ? "R4" : "R3", chk_resp_vld, evld);
            check("R3", chk_resp_data, evld ? (m['h31][0] ? 'h55 : 'hAA) : 0);
            check("R4", io_hit, eh);
            for (int k = 0; k < 2; k++) begin
                check("R7", irq_num[4*k +: 4], m['h70 + 2*k]);
                check("R7", irq_level_trig[k], m['h71 + 2*k] & 1);
                check("R7", irq_active_high[k], (m['h71 + 2*k] >> 1) & 1);
            end
            edma = 0;
            for (int j = 0; j < 2; j++)
                if (act && m['h74 + j] != 4) edma |= (1 << m['h74 + j]);
            check("R8", dma_en, edma);
        end
    end

    task automatic drive(bit s, bit w, int i, int d, bit rd, int a, bit c);
        cfg_sel = s; cfg_wr = w; cfg_idx = 8'(i); cfg_wdata = 8'(d);
        io_rd = rd; io_addr = 16'(a); cc_reset = c;
        @(posedge clk); #1;
    endtask

    task automatic wr(int i, int d);
        drive(1, 1, i, d, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R12: state after reset reads zero
        drive(1, 0, 'h30, 0, 0, 0, 0);
        check("R12", dev_active, 0);
        // Range 0 at 0x0220, probe armed with pattern 1, then pattern 0 (R3)
        wr('h60, 'h02); wr('h61, 'h20);
        wr('h31, 'h03);
        drive(0, 0, 0, 0, 1, 'h0224, 0);
        check("R3", chk_resp_data, 'h55);
        wr('h31, 'hFE);
        drive(0, 0, 0, 0, 1, 'h0227, 0);
        check("R3", chk_resp_data, 'hAA);
        drive(0, 0, 0, 0, 1, 'h0228, 0);
        check("R3", chk_resp_vld, 0);
        // R5: activation disarms the probe; R4 decode takes over
        wr('h30, 'hFF);
        drive(1, 0, 'h31, 0, 1, 'h0221, 0);
        check("R5", cfg_rdata, 'h00);
        check("R4", io_hit, 'h01);
        // R10: unselected write is ignored
        drive(0, 1, 'h30, 0, 0, 0, 0);
        drive(1, 0, 'h30, 0, 0, 0, 0);
        check("R10", cfg_rdata, 'h01);
        // R8: DMA entries, channel 4 means none
        wr('h74, 'h03); wr('h75, 'h04);
        drive(0, 0, 0, 0, 0, 0, 0);
        check("R8", dma_en, 'h08);
        // R11: control reset wins over a simultaneous write
        drive(1, 1, 'h30, 1, 0, 0, 1);
        drive(1, 0, 'h60, 0, 0, 0, 0);
        check("R11", cfg_rdata, 0);
        check("R11", dev_active, 0);
        // Random traffic over all indices and addresses near the bases
        for (int n = 0; n < 4000; n++) begin
            int sel, op, i, a;
            sel = $urandom % 6;
            case (sel)
                0: i = 'h30;
                1: i = 'h31;
                2: i = 'h40 + $urandom % 32;
                3: i = 'h60 + $urandom % 16;
                4: i = 'h70 + $urandom % 8;
                default: i = $urandom % 256;
            endcase
            op = $urandom % 4;
            if (op == 0) begin
                int r;
                r = $urandom % 8;
                a = m['h60 + 2*r] * 256 + m['h61 + 2*r] + $urandom % 12;
            end else a = $urandom % 65536;
            drive(($urandom % 8) != 0, ($urandom % 3) == 0, i, $urandom % 256,
                  ($urandom % 2) == 0, a, ($urandom % 200) == 0);
            if (n == 2500) begin
                // R12: mid-run reset clears everything
                rst_n = 0;
                @(posedge clk); #1;
                rst_n = 1;
                drive(1, 0, 'h31, 0, 0, 0, 0);
                check("R12", cfg_rdata, 0);
            end
        end
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule